// File: doc/BRIEF.md
# Zero-overhead hardware loop sequencer

This block steers the fetch address of a processor so that loops need no counter, compare or branch instructions. It holds two hardware loops, numbered 0 and 1. Each loop has a start address (the first instruction of the body), an end address (the last instruction of the body) and a remaining-iteration count. The pipeline presents the address of every retiring instruction. When that address equals the end address of a loop whose count is nonzero, the block sends the next fetch to that loop's start address and lowers the count by one. In every other case it falls through to the following address. The redirect is formed combinationally in the retire cycle, so a taken repeat costs no cycles.

Software programs the loops in one of two ways. It can write a single register of either loop, or it can issue a compact setup command. The setup command places the start and end addresses at unsigned word offsets from the command's own address, and it can load the count at the same time. When both loops end on the same instruction, loop 1 is the inner loop and gets the first chance to repeat. Loop 0 repeats only when loop 1 does not.

Each loop bank runs a two-state machine. In IDLE the count is zero, and in ARMED the count is nonzero. Transition ARM (IDLE to ARMED) happens when a write or setup loads a nonzero count. Transition EXPIRE (ARMED to IDLE) happens when a decrement or a load leaves the count at zero. The hold transitions keep the state otherwise. The selector takes one of three outcomes each cycle: SEL_SEQ (fall through), SEL_INNER (repeat loop 1) or SEL_OUTER (repeat loop 0).

Top module: `hwloop_seq`

## Requirements
- R1: After reset all start, end and count registers are zero, `loop_active` is 2'b00 and `redirect` is low.
- R2: When `retire_valid` is high, `retire_addr` equals a loop's end address and that loop's count is nonzero, `redirect` is high and `next_fetch` equals that loop's start address in the same cycle. The count drops by one at the next clock edge.
- R3: When the count is zero, or the address matches no end address, `redirect` is low and `next_fetch` is `retire_addr + 1`, wrapping modulo 2^ADDR_W.
- R4: A loop whose start equals its end repeats that one instruction once per unit of count, then falls through.
- R5: When both end addresses match, loop 1 is tested first. Loop 0 repeats only if loop 1 does not, and the count of loop 0 is untouched while loop 1 repeats.
- R6: A register write goes to loop `reg_wr_loop` and picks the register with `reg_wr_field`: 0 is start, 1 is end and 2 is count. A count write keeps the low CNT_W bits of `reg_wr_data`. Field code 3 changes nothing.
- R7: A setup command sets start = `setup_addr + setup_top_off` and end = `setup_addr + setup_bot_off`. Both offsets are zero-extended and the sums wrap modulo 2^ADDR_W. The count is loaded from `setup_count` only when `setup_load_cnt` is 1 and is otherwise kept.
- R8: An explicit count load (write or setup) in the cycle a loop repeats takes precedence over the decrement. The repeat itself is still taken on the old count.
- R9: If a register write and a setup target the same register of the same loop in one cycle, the register write wins.
- R10: `loop_active[i]` is high exactly when the count of loop i is nonzero.
- R11: With `retire_valid` low there is no redirect and no count changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| retire_valid | input | 1 | An instruction retires this cycle |
| retire_addr | input | ADDR_W | Address of the retiring instruction |
| reg_wr_en | input | 1 | Single-register write strobe |
| reg_wr_loop | input | 1 | Loop targeted by the write |
| reg_wr_field | input | 2 | 0 start, 1 end, 2 count, 3 none |
| reg_wr_data | input | ADDR_W | Write data |
| setup_valid | input | 1 | Setup command strobe |
| setup_loop | input | 1 | Loop targeted by the setup |
| setup_addr | input | ADDR_W | Address of the setup command |
| setup_top_off | input | TOP_OFF_W | Unsigned start offset |
| setup_bot_off | input | BOT_OFF_W | Unsigned end offset |
| setup_load_cnt | input | 1 | Also load the count |
| setup_count | input | CNT_W | Count value for the setup |
| next_fetch | output | ADDR_W | Next fetch address |
| redirect | output | 1 | A loop repeat is taken this cycle |
| loop_active | output | 2 | Per-loop count-nonzero flags |

## Verification
The bench builds the block with ADDR_W=12 and CNT_W=4, leaving both offset widths at their defaults of 5 and 10. With these values a 10-bit end offset from a setup near the top of the address space wraps past zero. A count write with bits above bit 3 shows the truncation. Both loop counts can be driven to the point where they run out within a few dozen cycles. A nested program run feeds `next_fetch` back as the next retire address, so the shared-end priority is exercised over full inner and outer passes.

// File: rtl/hwloop_pkg.sv
package hwloop_pkg;

    localparam int NUM_LOOPS = 2;

    typedef enum logic [1:0] {
        FLD_TOP    = 2'd0,
        FLD_BOTTOM = 2'd1,
        FLD_COUNT  = 2'd2,
        FLD_NONE   = 2'd3
    } loop_field_e;

    typedef enum logic {
        LOOP_IDLE  = 1'b0,
        LOOP_ARMED = 1'b1
    } loop_state_e;

    typedef enum logic [1:0] {
        SEL_SEQ   = 2'd0,
        SEL_INNER = 2'd1,
        SEL_OUTER = 2'd2
    } fetch_sel_e;

endpackage

// File: rtl/hwloop_setup_dec.sv
module hwloop_setup_dec
    import hwloop_pkg::*;
#(
    parameter int ADDR_W    = 16,
    parameter int TOP_OFF_W = 5,
    parameter int BOT_OFF_W = 10
) (
    input  logic                 setup_valid,
    input  logic                 setup_loop,
    input  logic [ADDR_W-1:0]    setup_addr,
    input  logic [TOP_OFF_W-1:0] setup_top_off,
    input  logic [BOT_OFF_W-1:0] setup_bot_off,
    input  logic                 setup_load_cnt,
    output logic [NUM_LOOPS-1:0] setup_en,
    output logic [NUM_LOOPS-1:0] setup_cnt_en,
    output logic [ADDR_W-1:0]    setup_top,
    output logic [ADDR_W-1:0]    setup_bot
);

    // Offsets are unsigned word distances from the setup command itself.
    assign setup_top = setup_addr + ADDR_W'(setup_top_off);
    assign setup_bot = setup_addr + ADDR_W'(setup_bot_off);

    for (genvar g = 0; g < NUM_LOOPS; g++) begin : g_sel
        assign setup_en[g]     = setup_valid && (setup_loop == 1'(g));
        assign setup_cnt_en[g] = setup_valid && setup_load_cnt && (setup_loop == 1'(g));
    end

endmodule

// File: rtl/hwloop_bank.sv
module hwloop_bank
    import hwloop_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int CNT_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  loop_field_e       wr_field,
    input  logic [ADDR_W-1:0] wr_data,
    input  logic              setup_en,
    input  logic              setup_cnt_en,
    input  logic [ADDR_W-1:0] setup_top,
    input  logic [ADDR_W-1:0] setup_bot,
    input  logic [CNT_W-1:0]  setup_cnt,
    input  logic              repeat_take,
    output logic [ADDR_W-1:0] top_q,
    output logic [ADDR_W-1:0] bot_q,
    output logic [CNT_W-1:0]  cnt_q,
    output logic              armed
);

    loop_state_e       state_q, state_d;
    logic [ADDR_W-1:0] top_d, bot_d;
    logic [CNT_W-1:0]  cnt_d;
    logic              wr_cnt_hit;

    assign wr_cnt_hit = wr_en && (wr_field == FLD_COUNT);

    // Next-value logic: decrement, then setup, then register write (highest).
    always_comb begin
        top_d = top_q;
        bot_d = bot_q;
        cnt_d = cnt_q;
        if (repeat_take) begin
            cnt_d = cnt_q - CNT_W'(1);
        end
        if (setup_en) begin
            top_d = setup_top;
            bot_d = setup_bot;
        end
        if (setup_cnt_en) begin
            cnt_d = setup_cnt;
        end
        if (wr_en) begin
            unique case (wr_field)
                FLD_TOP:    top_d = wr_data;
                FLD_BOTTOM: bot_d = wr_data;
                FLD_COUNT:  cnt_d = wr_data[CNT_W-1:0];
                default:    ;
            endcase
        end
    end

    // ARM / EXPIRE / hold transitions.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            LOOP_IDLE:  if (cnt_d != '0) state_d = LOOP_ARMED;
            LOOP_ARMED: if (cnt_d == '0) state_d = LOOP_IDLE;
            default:    state_d = LOOP_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= LOOP_IDLE;
            top_q   <= '0;
            bot_q   <= '0;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            top_q   <= top_d;
            bot_q   <= bot_d;
            cnt_q   <= cnt_d;
        end
    end

    always_comb begin
        unique case (state_q)
            LOOP_ARMED: armed = 1'b1;
            default:    armed = 1'b0;
        endcase
    end

    // R2: a repeat without any explicit load lowers the count by exactly one.
    a_r2_decrement: assert property (@(posedge clk) disable iff (!rst_n)
        (repeat_take && !wr_cnt_hit && !setup_cnt_en) |=> (cnt_q == $past(cnt_q) - CNT_W'(1)));

    // R8: an explicit count write beats the decrement.
    a_r8_write_wins: assert property (@(posedge clk) disable iff (!rst_n)
        wr_cnt_hit |=> (cnt_q == $past(wr_data[CNT_W-1:0])));

    // R3: the selector never repeats a loop whose count is zero.
    a_r3_no_take_idle: assert property (@(posedge clk) disable iff (!rst_n)
        repeat_take |-> armed);

    // R10: the state machine tracks the count register.
    a_r10_armed_tracks: assert property (@(posedge clk) disable iff (!rst_n)
        armed == (cnt_q != '0));

endmodule

// File: rtl/hwloop_arb.sv
module hwloop_arb
    import hwloop_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 retire_valid,
    input  logic [ADDR_W-1:0]    retire_addr,
    input  logic [ADDR_W-1:0]    top0,
    input  logic [ADDR_W-1:0]    bot0,
    input  logic [ADDR_W-1:0]    top1,
    input  logic [ADDR_W-1:0]    bot1,
    input  logic [NUM_LOOPS-1:0] armed,
    output logic [NUM_LOOPS-1:0] take,
    output logic                 redirect,
    output logic [ADDR_W-1:0]    next_fetch
);

    fetch_sel_e sel;
    logic       hit0, hit1;

    assign hit0 = retire_valid && (retire_addr == bot0);
    assign hit1 = retire_valid && (retire_addr == bot1);

    // Inner loop (1) is considered before outer loop (0).
    always_comb begin
        sel = SEL_SEQ;
        if (hit1 && armed[1]) begin
            sel = SEL_INNER;
        end else if (hit0 && armed[0]) begin
            sel = SEL_OUTER;
        end
    end

    always_comb begin
        take       = '0;
        redirect   = 1'b0;
        next_fetch = retire_addr + ADDR_W'(1);
        unique case (sel)
            SEL_INNER: begin
                take[1]    = 1'b1;
                redirect   = 1'b1;
                next_fetch = top1;
            end
            SEL_OUTER: begin
                take[0]    = 1'b1;
                redirect   = 1'b1;
                next_fetch = top0;
            end
            default: ;
        endcase
    end

    // R5: at most one loop repeats, and a matching armed inner loop blocks the outer.
    a_r5_one_winner: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(take));
    a_r5_inner_first: assert property (@(posedge clk) disable iff (!rst_n)
        (hit1 && armed[1]) |-> !take[0]);

    // R11: nothing retires, nothing redirects.
    a_r11_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !retire_valid |-> (!redirect && (take == '0)));

endmodule

// File: rtl/hwloop_seq.sv
module hwloop_seq
    import hwloop_pkg::*;
#(
    parameter int ADDR_W    = 16,
    parameter int CNT_W     = 16,
    parameter int TOP_OFF_W = 5,
    parameter int BOT_OFF_W = 10
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 retire_valid,
    input  logic [ADDR_W-1:0]    retire_addr,
    input  logic                 reg_wr_en,
    input  logic                 reg_wr_loop,
    input  logic [1:0]           reg_wr_field,
    input  logic [ADDR_W-1:0]    reg_wr_data,
    input  logic                 setup_valid,
    input  logic                 setup_loop,
    input  logic [ADDR_W-1:0]    setup_addr,
    input  logic [TOP_OFF_W-1:0] setup_top_off,
    input  logic [BOT_OFF_W-1:0] setup_bot_off,
    input  logic                 setup_load_cnt,
    input  logic [CNT_W-1:0]     setup_count,
    output logic [ADDR_W-1:0]    next_fetch,
    output logic                 redirect,
    output logic [1:0]           loop_active
);

    logic [NUM_LOOPS-1:0]             s_en, s_cnt_en, take, armed;
    logic [ADDR_W-1:0]                s_top, s_bot;
    logic [NUM_LOOPS-1:0][ADDR_W-1:0] tops, bots;
    logic [NUM_LOOPS-1:0][CNT_W-1:0]  cnts;
    loop_field_e                      wr_field;

    assign wr_field = loop_field_e'(reg_wr_field);

    hwloop_setup_dec #(
        .ADDR_W   (ADDR_W),
        .TOP_OFF_W(TOP_OFF_W),
        .BOT_OFF_W(BOT_OFF_W)
    ) u_setup (
        .setup_valid   (setup_valid),
        .setup_loop    (setup_loop),
        .setup_addr    (setup_addr),
        .setup_top_off (setup_top_off),
        .setup_bot_off (setup_bot_off),
        .setup_load_cnt(setup_load_cnt),
        .setup_en      (s_en),
        .setup_cnt_en  (s_cnt_en),
        .setup_top     (s_top),
        .setup_bot     (s_bot)
    );

    for (genvar g = 0; g < NUM_LOOPS; g++) begin : g_bank
        hwloop_bank #(
            .ADDR_W(ADDR_W),
            .CNT_W (CNT_W)
        ) u_bank (
            .clk         (clk),
            .rst_n       (rst_n),
            .wr_en       (reg_wr_en && (reg_wr_loop == 1'(g))),
            .wr_field    (wr_field),
            .wr_data     (reg_wr_data),
            .setup_en    (s_en[g]),
            .setup_cnt_en(s_cnt_en[g]),
            .setup_top   (s_top),
            .setup_bot   (s_bot),
            .setup_cnt   (setup_count),
            .repeat_take (take[g]),
            .top_q       (tops[g]),
            .bot_q       (bots[g]),
            .cnt_q       (cnts[g]),
            .armed       (armed[g])
        );
    end

    hwloop_arb #(
        .ADDR_W(ADDR_W)
    ) u_arb (
        .clk         (clk),
        .rst_n       (rst_n),
        .retire_valid(retire_valid),
        .retire_addr (retire_addr),
        .top0        (tops[0]),
        .bot0        (bots[0]),
        .top1        (tops[1]),
        .bot1        (bots[1]),
        .armed       (armed),
        .take        (take),
        .redirect    (redirect),
        .next_fetch  (next_fetch)
    );

    assign loop_active = armed;

    // R7: a setup with count load leaves the selected count equal to the command's value.
    a_r7_setup_count: assert property (@(posedge clk) disable iff (!rst_n)
        (setup_valid && setup_load_cnt && !(reg_wr_en && (reg_wr_loop == setup_loop)
            && (wr_field == FLD_COUNT)))
        |=> (cnts[$past(setup_loop)] == $past(setup_count)));

endmodule

// File: tb/test_hwloop_seq.sv
`timescale 1ns/1ps
module test_hwloop_seq;

    localparam int AW    = 12;
    localparam int CW    = 4;
    localparam int AMASK = (1 << AW) - 1;
    localparam int CMASK = (1 << CW) - 1;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          rv = 1'b0;
    logic [AW-1:0] ra = '0;
    logic          wen = 1'b0;
    logic          wloop = 1'b0;
    logic [1:0]    wfld = 2'd0;
    logic [AW-1:0] wdata = '0;
    logic          sv = 1'b0;
    logic          sloop = 1'b0;
    logic [AW-1:0] sa = '0;
    logic [4:0]    sto = '0;
    logic [9:0]    sbo = '0;
    logic          sload = 1'b0;
    logic [CW-1:0] scnt = '0;
    logic [AW-1:0] next_fetch;
    logic          redirect;
    logic [1:0]    loop_active;

    int m_top[2];
    int m_bot[2];
    int m_cnt[2];
    int m_nf;
    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    hwloop_seq #(.ADDR_W(AW), .CNT_W(CW)) i_hwloop_seq (
        .clk(clk), .rst_n(rst_n),
        .retire_valid(rv), .retire_addr(ra),
        .reg_wr_en(wen), .reg_wr_loop(wloop), .reg_wr_field(wfld), .reg_wr_data(wdata),
        .setup_valid(sv), .setup_loop(sloop), .setup_addr(sa),
        .setup_top_off(sto), .setup_bot_off(sbo), .setup_load_cnt(sload), .setup_count(scnt),
        .next_fetch(next_fetch), .redirect(redirect), .loop_active(loop_active)
    );

    task automatic chk(input string tag, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    task automatic clear_ctl();
        rv = 0; wen = 0; sv = 0; sload = 0;
    endtask

    // Compare at the falling edge, then advance the model to the next cycle.
    task automatic tick(input string tag);
        bit t0, t1;
        int nc[2];
        @(negedge clk);
        t1 = rv && (int'(ra) == m_bot[1]) && (m_cnt[1] != 0);
        t0 = rv && (int'(ra) == m_bot[0]) && (m_cnt[0] != 0) && !t1;
        m_nf = t1 ? m_top[1] : (t0 ? m_top[0] : ((int'(ra) + 1) & AMASK));
        chk(tag, "next_fetch", int'(next_fetch), m_nf);
        chk(tag, "redirect", int'(redirect), int'(t0 || t1));
        chk(tag, "loop_active", int'(loop_active),
            ((m_cnt[1] != 0) ? 2 : 0) + ((m_cnt[0] != 0) ? 1 : 0));
        nc[0] = t0 ? m_cnt[0] - 1 : m_cnt[0];
        nc[1] = t1 ? m_cnt[1] - 1 : m_cnt[1];
        if (sv) begin
            m_top[sloop] = (int'(sa) + int'(sto)) & AMASK;
            m_bot[sloop] = (int'(sa) + int'(sbo)) & AMASK;
            if (sload) nc[sloop] = int'(scnt);
        end
        if (wen) begin
            case (wfld)
                2'd0: m_top[wloop] = int'(wdata);
                2'd1: m_bot[wloop] = int'(wdata);
                2'd2: nc[wloop] = int'(wdata) & CMASK;
                default: ;
            endcase
        end
        m_cnt[0] = nc[0];
        m_cnt[1] = nc[1];
        @(posedge clk);
        #1;
    endtask

    task automatic wr(input string tag, input bit lp, input int fld, input int data);
        wen = 1; wloop = lp; wfld = 2'(fld); wdata = AW'(data);
        tick(tag);
        clear_ctl();
    endtask

    task automatic setup(input string tag, input bit lp, input int addr, input int to,
                         input int bo, input bit ld, input int c);
        sv = 1; sloop = lp; sa = AW'(addr); sto = 5'(to); sbo = 10'(bo);
        sload = ld; scnt = CW'(c);
        tick(tag);
        clear_ctl();
    endtask

    task automatic retire(input string tag, input int addr);
        rv = 1; ra = AW'(addr);
        tick(tag);
        clear_ctl();
    endtask

    // Runs a program: each retire address is the previously expected fetch.
    task automatic run(input string tag, input int start, input int n);
        ra = AW'(start);
        for (int k = 0; k < n; k++) begin
            rv = 1;
            tick(tag);
            ra = AW'(m_nf);
        end
        clear_ctl();
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            done = 1;
            errors++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 2; i++) begin
            m_top[i] = 0; m_bot[i] = 0; m_cnt[i] = 0;
        end
        repeat (3) @(posedge clk);
        #1 rst_n = 1;

        // R1: reset state, idle cycle and retire of address 0 (end 0, count 0)
        tick("R1");
        retire("R1", 0);

        // R6: program loop 0 by register writes; R2 / R3: run its body
        wr("R6", 0, 0, 'h10);
        wr("R6", 0, 1, 'h13);
        wr("R6", 0, 2, 2);
        run("R2", 'h10, 12);
        retire("R3", 'h13);
        retire("R3", 'h77);

        // R6: field code 3 changes nothing; loop 0 stays idle
        wr("R6", 0, 3, 'h5);
        retire("R6", 'h13);
        // R6: count write truncated to CW bits (0x123 -> 3)
        wr("R6", 0, 2, 'h123);
        tick("R10");

        // R11: no retire valid at the end address: no redirect, count held
        ra = AW'('h13);
        tick("R11");
        tick("R11");
        run("R11", 'h10, 16);

        // R4 / R7: single-instruction loop through setup with count
        setup("R7", 1, 'h100, 3, 3, 1, 3);
        for (int k = 0; k < 4; k++) retire("R4", 'h103);
        retire("R4", 'h103);

        // R7: setup without count load keeps count 0; max offsets
        setup("R7", 1, 'h200, 31, 1023, 0, 9);
        tick("R7");
        wr("R7", 1, 2, 1);
        retire("R7", 'h5FF);
        retire("R7", 'h5FF);

        // R7: end offset wraps past the top of the address space
        setup("R7", 0, 'hFF0, 2, 'h20, 1, 1);
        retire("R7", 'h010);
        retire("R7", 'h010);

        // R5: shared end address, loop 1 inner, loop 0 outer
        wr("R5", 0, 0, 'h40);
        wr("R5", 0, 1, 'h50);
        wr("R5", 0, 2, 2);
        setup("R5", 1, 'h48, 0, 8, 1, 2);
        run("R5", 'h40, 60);

        // R8: count write in the cycle of a repeat wins over the decrement
        wr("R8", 0, 1, 'h13);
        wr("R8", 0, 0, 'h10);
        wr("R8", 0, 2, 3);
        rv = 1; ra = AW'('h13); wen = 1; wloop = 0; wfld = 2'd2; wdata = AW'(9);
        tick("R8");
        clear_ctl();
        retire("R8", 'h13);
        // R8: setup count load in the cycle of a repeat also wins
        rv = 1; ra = AW'('h13); sv = 1; sloop = 0; sa = AW'('h10); sto = 0; sbo = 3;
        sload = 1; scnt = CW'(1);
        tick("R8");
        clear_ctl();
        retire("R8", 'h13);
        retire("R8", 'h13);

        // R9: write and setup of the same loop in one cycle, write wins on start
        sv = 1; sloop = 1; sa = AW'('h300); sto = 4; sbo = 6; sload = 1; scnt = CW'(2);
        wen = 1; wloop = 1; wfld = 2'd0; wdata = AW'('h2F0);
        tick("R9");
        clear_ctl();
        retire("R9", 'h306);
        // R9: count write beats setup count
        sv = 1; sloop = 1; sa = AW'('h300); sto = 4; sbo = 6; sload = 1; scnt = CW'(5);
        wen = 1; wloop = 1; wfld = 2'd2; wdata = AW'(0);
        tick("R9");
        clear_ctl();
        retire("R9", 'h306);
        tick("R10");

        if (!done) begin
            done = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule